// File: doc/BRIEF.md
# Machine-Cycle Bus Request Arbiter

This block chooses which pending request a small processor core serves next. The candidates are a wait input, a periodic refresh request, two DMA request lines, an external bus request and three maskable interrupt lines. What the block accepts depends on the status it is in: normal, wait state, refresh cycle, interrupt acknowledge, DMA cycle, bus release, sleep or system stop. There is no fixed priority. Each status has its own set of requests it will accept, and a grant only takes effect at a machine-cycle boundary or an instruction boundary.

The core marks boundaries with two strobes. `mc_end_i` marks the last clock of a machine cycle. `instr_end_i`, given together with `mc_end_i`, marks the last machine cycle of an instruction. A sleep or stop command enters a low-power status at an instruction boundary. That status is left only through a bus request or an interrupt.

If a DMA request arrives while the block is in refresh, it is latched and served one boundary after the refresh ends. The same happens to a DMA request that arrives during a bus release entered from normal operation. It is served one boundary after the bus is taken back.

Top module: `mc_arbiter`

## Requirements
- R1: After reset, status_o is 8'b0000_0001 (normal). No DMA grant, no interrupt select, no bus acknowledge and no stall is active. The status bits are: 0 normal, 1 wait, 2 refresh, 3 interrupt acknowledge, 4 DMA, 5 bus release, 6 sleep, 7 stop.
- R2: stall_o equals wait_i while the status is normal, wait, interrupt acknowledge or DMA, and is 0 in every other status. From normal, a stall moves the block to wait on the next clock. Wait status lasts as long as wait_i is held, and the interrupt acknowledge and DMA statuses are held while stalled.
- R3: A boundary is a clock with mc_end_i high and stall_o low. Refresh, DMA, interrupt acknowledge and bus release change only at a boundary, except for the wake events of R9 and R10. Any served status with no new grant returns to normal at a boundary.
- R4: A refresh request at a boundary in normal, interrupt acknowledge or DMA status enters refresh on the next clock. At a boundary in wait status it is not taken, and the block goes to normal.
- R5: A DMA request at a boundary in normal, wait, interrupt acknowledge or DMA status enters DMA. dma_gnt_o is then one-hot on the granted channel, and the lower channel index wins.
- R6: A DMA request seen during refresh is latched. Refresh still ends in normal at its boundary, and the DMA cycle starts at the following boundary even if the request line has dropped.
- R7: A DMA request seen during a bus release entered from normal is latched. The DMA cycle starts at the first boundary after the release ends.
- R8: A bus request at a boundary in normal, interrupt acknowledge or DMA status enters bus release, with busack_o high. In wait or refresh status it is not taken. Bus release holds while busreq_i stays high and ends at the first boundary with busreq_i low.
- R9: At an instruction boundary in normal status with no other grant, stop_cmd_i enters stop and sleep_cmd_i enters sleep; stop wins when both are given. In sleep or stop, wait, refresh and DMA requests are ignored. A bus request enters bus release on the next clock, and the block returns to that low-power status when the release ends.
- R10: An interrupt is taken only at a boundary with instr_end_i high in normal or wait status. The block then enters interrupt acknowledge, with irq_sel_o one-hot on the lowest pending line. Interrupts are ignored in refresh, interrupt acknowledge, DMA and bus release. In sleep or stop, with no bus request, any interrupt returns the block to normal on the next clock.
- R11: When several accepted requests meet at one boundary, the grant goes to refresh first, then bus request, then DMA channel 0, then DMA channel 1, then interrupts.
- R12: status_o always has exactly one bit set. dma_gnt_o is non-zero exactly in DMA status and irq_sel_o is non-zero exactly in interrupt acknowledge status, each with at most one bit set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock |
| rst_ni | input | 1 | Asynchronous reset, active low |
| wait_i | input | 1 | Wait request from slow memory or I/O |
| rfsh_req_i | input | 1 | Refresh request, held until served |
| dreq_i | input | N_DMA | DMA request per channel |
| busreq_i | input | 1 | External bus request |
| irq_i | input | N_IRQ | Maskable interrupt lines |
| mc_end_i | input | 1 | Last clock of the current machine cycle |
| instr_end_i | input | 1 | Current machine cycle ends an instruction |
| sleep_cmd_i | input | 1 | Enter sleep at the instruction boundary |
| stop_cmd_i | input | 1 | Enter system stop at the instruction boundary |
| status_o | output | 8 | One-hot current status |
| stall_o | output | 1 | Machine cycle stretched by an honoured wait |
| busack_o | output | 1 | Bus released to an external master |
| dma_gnt_o | output | N_DMA | One-hot granted DMA channel |
| irq_sel_o | output | N_IRQ | One-hot interrupt being acknowledged |

## Verification
The collision that matters most is a wait request on the same clock as a machine-cycle end. A wait that the status honours must cancel the boundary, and a wait that the status ignores must not. The bench steers the block into each of the eight statuses and applies each request together with both boundary strobes. It then compares the next status, grant and stall against a table derived from R2 to R10. A second collision is several requests qualifying at one boundary. The bench sweeps every subset of refresh, bus, both DMA channels and an interrupt from normal status and judges the winner by the R11 order. Directed sequences cover the latched DMA after refresh and after bus release.

// File: rtl/mc_arb_pkg.sv
package mc_arb_pkg;
  localparam int unsigned NUM_ST = 8;

  typedef enum logic [2:0] {
    ST_NORM  = 3'd0,
    ST_WAIT  = 3'd1,
    ST_RFSH  = 3'd2,
    ST_IACK  = 3'd3,
    ST_DMA   = 3'd4,
    ST_BREL  = 3'd5,
    ST_SLEEP = 3'd6,
    ST_STOP  = 3'd7
  } arb_st_e;

  typedef struct packed {
    logic wait_ok;
    logic rfsh_ok;
    logic bus_ok;
    logic dma_ok;
    logic irq_ok;
  } acc_t;
endpackage

// File: rtl/mc_arb_accept.sv
module mc_arb_accept
  import mc_arb_pkg::*;
(
  input  arb_st_e st_i,
  output acc_t    acc_o
);
  always_comb begin
    acc_o = '0;
    unique case (st_i)
      ST_NORM: acc_o = '{wait_ok: 1'b1, rfsh_ok: 1'b1, bus_ok: 1'b1, dma_ok: 1'b1, irq_ok: 1'b1};
      ST_WAIT: acc_o = '{wait_ok: 1'b1, rfsh_ok: 1'b0, bus_ok: 1'b0, dma_ok: 1'b1, irq_ok: 1'b1};
      ST_IACK: acc_o = '{wait_ok: 1'b1, rfsh_ok: 1'b1, bus_ok: 1'b1, dma_ok: 1'b1, irq_ok: 1'b0};
      ST_DMA:  acc_o = '{wait_ok: 1'b1, rfsh_ok: 1'b1, bus_ok: 1'b1, dma_ok: 1'b1, irq_ok: 1'b0};
      default: acc_o = '0;
    endcase
  end
endmodule

// File: rtl/mc_arb_pick.sv
module mc_arb_pick #(
  parameter int unsigned W = 4
) (
  input  logic [W-1:0] req_i,
  output logic [W-1:0] gnt_o,
  output logic         any_o
);
  // lowest index wins
  always_comb begin
    gnt_o = '0;
    for (int i = W - 1; i >= 0; i--) begin
      if (req_i[i]) begin
        gnt_o    = '0;
        gnt_o[i] = 1'b1;
      end
    end
  end
  assign any_o = |req_i;
endmodule

// File: rtl/mc_arb_pend.sv
module mc_arb_pend #(
  parameter int unsigned N_CH = 2
) (
  input  logic            clk_i,
  input  logic            rst_ni,
  input  logic [N_CH-1:0] set_i,
  input  logic [N_CH-1:0] clr_i,
  output logic [N_CH-1:0] pend_o
);
  for (genvar c = 0; c < N_CH; c++) begin : g_ch
    logic q;
    always_ff @(posedge clk_i or negedge rst_ni) begin
      if (!rst_ni)       q <= 1'b0;
      else if (clr_i[c]) q <= 1'b0;
      else if (set_i[c]) q <= 1'b1;
    end
    assign pend_o[c] = q;
  end
endmodule

// File: rtl/mc_arbiter.sv
module mc_arbiter
  import mc_arb_pkg::*;
#(
  parameter int unsigned N_DMA = 2,
  parameter int unsigned N_IRQ = 3
) (
  input  logic              clk_i,
  input  logic              rst_ni,
  input  logic              wait_i,
  input  logic              rfsh_req_i,
  input  logic [N_DMA-1:0]  dreq_i,
  input  logic              busreq_i,
  input  logic [N_IRQ-1:0]  irq_i,
  input  logic              mc_end_i,
  input  logic              instr_end_i,
  input  logic              sleep_cmd_i,
  input  logic              stop_cmd_i,
  output logic [NUM_ST-1:0] status_o,
  output logic              stall_o,
  output logic              busack_o,
  output logic [N_DMA-1:0]  dma_gnt_o,
  output logic [N_IRQ-1:0]  irq_sel_o
);
  localparam int unsigned N_CLS = 4;  // rfsh, bus, dma, irq

  arb_st_e st_q, st_d, org_q, org_d;
  logic [N_DMA-1:0] dma_q, dma_d, pend, pend_set, pend_clr, dma_eff, dma_pick;
  logic [N_IRQ-1:0] irq_q, irq_d, irq_pick;
  logic [N_CLS-1:0] cls_req, cls_g;
  logic             dma_any, irq_any, cls_any, stall, bnd;
  acc_t             acc;

  mc_arb_accept u_accept (.st_i(st_q), .acc_o(acc));

  assign stall   = wait_i & acc.wait_ok;
  assign bnd     = mc_end_i & ~stall;
  assign dma_eff = dreq_i | pend;

  mc_arb_pick #(.W(N_DMA)) u_pick_dma (.req_i(dma_eff), .gnt_o(dma_pick), .any_o(dma_any));
  mc_arb_pick #(.W(N_IRQ)) u_pick_irq (.req_i(irq_i),   .gnt_o(irq_pick), .any_o(irq_any));

  assign cls_req[0] = acc.rfsh_ok & rfsh_req_i;
  assign cls_req[1] = acc.bus_ok  & busreq_i;
  assign cls_req[2] = acc.dma_ok  & dma_any;
  assign cls_req[3] = acc.irq_ok  & instr_end_i & irq_any;

  mc_arb_pick #(.W(N_CLS)) u_pick_cls (.req_i(cls_req), .gnt_o(cls_g), .any_o(cls_any));

  // latch DMA seen while refresh or a normal-origin release owns the cycle
  assign pend_set = ((st_q == ST_RFSH) || (st_q == ST_BREL && org_q == ST_NORM))
                    ? dreq_i : '0;
  assign pend_clr = (bnd & cls_g[2]) ? dma_pick : '0;

  mc_arb_pend #(.N_CH(N_DMA)) u_pend (
    .clk_i (clk_i),
    .rst_ni(rst_ni),
    .set_i (pend_set),
    .clr_i (pend_clr),
    .pend_o(pend)
  );

  always_comb begin
    st_d  = st_q;
    org_d = org_q;
    dma_d = dma_q;
    irq_d = irq_q;
    unique case (st_q)
      ST_SLEEP, ST_STOP: begin
        if (busreq_i) begin
          st_d  = ST_BREL;
          org_d = st_q;
        end else if (irq_any) begin
          st_d = ST_NORM;
        end
      end
      ST_BREL: begin
        if (mc_end_i && !busreq_i) begin
          st_d  = org_q;
          org_d = ST_NORM;
        end
      end
      default: begin
        if (stall) begin
          if (st_q == ST_NORM) st_d = ST_WAIT;
        end else if (bnd) begin
          dma_d = '0;
          irq_d = '0;
          if (cls_any) begin
            if (cls_g[0]) st_d = ST_RFSH;
            else if (cls_g[1]) begin
              st_d  = ST_BREL;
              org_d = ST_NORM;
            end else if (cls_g[2]) begin
              st_d  = ST_DMA;
              dma_d = dma_pick;
            end else begin
              st_d  = ST_IACK;
              irq_d = irq_pick;
            end
          end else if (st_q == ST_NORM && instr_end_i && stop_cmd_i) begin
            st_d = ST_STOP;
          end else if (st_q == ST_NORM && instr_end_i && sleep_cmd_i) begin
            st_d = ST_SLEEP;
          end else begin
            st_d = ST_NORM;
          end
        end else if (st_q == ST_WAIT) begin
          st_d = ST_NORM;
        end
      end
    endcase
  end

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      st_q  <= ST_NORM;
      org_q <= ST_NORM;
      dma_q <= '0;
      irq_q <= '0;
    end else begin
      st_q  <= st_d;
      org_q <= org_d;
      dma_q <= dma_d;
      irq_q <= irq_d;
    end
  end

  assign status_o  = NUM_ST'(1) << st_q;
  assign stall_o   = stall;
  assign busack_o  = (st_q == ST_BREL);
  assign dma_gnt_o = dma_q;
  assign irq_sel_o = irq_q;
endmodule

// File: rtl/mc_arbiter_chk.sv
module mc_arbiter_chk #(
  parameter int unsigned N_DMA = 2,
  parameter int unsigned N_IRQ = 3
) (
  input logic             clk_i,
  input logic             rst_ni,
  input logic             wait_i,
  input logic             rfsh_req_i,
  input logic [N_DMA-1:0] dreq_i,
  input logic             busreq_i,
  input logic [N_IRQ-1:0] irq_i,
  input logic             mc_end_i,
  input logic [7:0]       status_o,
  input logic             stall_o,
  input logic             busack_o,
  input logic [N_DMA-1:0] dma_gnt_o,
  input logic [N_IRQ-1:0] irq_sel_o
);
  p_onehot_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    $countones(status_o) == 1);
  p_dma_gnt_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[4] == (|dma_gnt_o) && $countones(dma_gnt_o) <= 1);
  p_irq_sel_r12: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[3] == (|irq_sel_o) && $countones(irq_sel_o) <= 1);
  p_busack_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    busack_o |-> status_o[5]);
  p_stall_ign_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[2] || status_o[5] || status_o[6] || status_o[7]) |-> !stall_o);
  p_wait_enter_r2: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && wait_i) |=> status_o[1]);
  p_rfsh_hold_r3: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[2] && !mc_end_i) |=> status_o[2]);
  p_rfsh_wait_r4: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[1] && rfsh_req_i) |=> !status_o[2]);
  p_dma_ch0_r5: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && mc_end_i && !wait_i && !rfsh_req_i && !busreq_i &&
     dreq_i == N_DMA'(1)) |=> dma_gnt_o[0]);
  p_rfsh_dma_r6: assert property (@(posedge clk_i) disable iff (!rst_ni)
    status_o[2] |=> !status_o[4]);
  p_brel_hold_r8: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[5] && busreq_i) |=> status_o[5]);
  p_sleep_ign_r9: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[6] && !busreq_i && !(|irq_i)) |=> status_o[6]);
  p_wake_r10: assert property (@(posedge clk_i) disable iff (!rst_ni)
    ((status_o[6] || status_o[7]) && !busreq_i && (|irq_i)) |=> status_o[0]);
  p_rfsh_first_r11: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (status_o[0] && mc_end_i && !wait_i && rfsh_req_i) |=> status_o[2]);
endmodule

bind mc_arbiter mc_arbiter_chk #(.N_DMA(N_DMA), .N_IRQ(N_IRQ)) u_chk (.*);

// File: tb/mc_arbiter_tb_top.sv
`timescale 1ns/1ps
module mc_arbiter_tb_top;
  logic       clk_i = 1'b0;
  logic       rst_ni = 1'b0;
  logic       wait_i, rfsh_req_i, busreq_i, mc_end_i, instr_end_i, sleep_cmd_i, stop_cmd_i;
  logic [1:0] dreq_i;
  logic [2:0] irq_i;
  logic [7:0] status_o;
  logic       stall_o, busack_o;
  logic [1:0] dma_gnt_o;
  logic [2:0] irq_sel_o;

  int checks = 0;
  int errors = 0;
  bit done = 1'b0;

  always #2 clk_i = ~clk_i;

  mc_arbiter #(.N_DMA(2), .N_IRQ(3)) dut_i (.*);

  task automatic chk(string tag, int got, int exp);
    checks++;
    if (got != exp) begin
      errors++;
      $display("FAIL %s got %0h exp %0h", tag, got, exp);
    end
  endtask

  task automatic clr_in();
    wait_i = 0; rfsh_req_i = 0; busreq_i = 0; mc_end_i = 0; instr_end_i = 0;
    sleep_cmd_i = 0; stop_cmd_i = 0; dreq_i = '0; irq_i = '0;
  endtask

  task automatic tick();
    @(posedge clk_i);
    @(negedge clk_i);
  endtask

  task automatic do_reset();
    clr_in();
    @(negedge clk_i);
    rst_ni = 0;
    @(negedge clk_i);
    @(negedge clk_i);
    rst_ni = 1;
    @(negedge clk_i);
  endtask

  task automatic chk_out(string tag, int st, int g, int q);
    chk({tag, " status"}, int'(status_o), 1 << st);
    chk({tag, " dma_gnt"}, int'(dma_gnt_o), g);
    chk({tag, " irq_sel"}, int'(irq_sel_o), q);
    chk({tag, " busack"}, int'(busack_o), int'(st == 5));
  endtask

  task automatic steer(int s);
    do_reset();
    case (s)
      1: begin wait_i = 1; end
      2: begin rfsh_req_i = 1; mc_end_i = 1; end
      3: begin irq_i = 3'b001; mc_end_i = 1; instr_end_i = 1; end
      4: begin dreq_i = 2'b01; mc_end_i = 1; end
      5: begin busreq_i = 1; mc_end_i = 1; end
      6: begin sleep_cmd_i = 1; mc_end_i = 1; instr_end_i = 1; end
      7: begin stop_cmd_i = 1; mc_end_i = 1; instr_end_i = 1; end
      default: ;
    endcase
    if (s != 0) tick();
    chk("R3 steer", int'(status_o), 1 << s);
  endtask

  // next status from the acceptance rules, request r with both strobes high
  function automatic int exp_st(int s, int r);
    bit irq = (r >= 5);
    bit dma = (r == 2 || r == 3);
    case (s)
      0: return r == 0 ? 1 : r == 1 ? 2 : dma ? 4 : r == 4 ? 5 : 3;
      1: return r == 0 ? 1 : dma ? 4 : irq ? 3 : 0;
      2: return 0;
      3: return r == 0 ? 3 : r == 1 ? 2 : dma ? 4 : r == 4 ? 5 : 0;
      4: return r == 0 ? 4 : r == 1 ? 2 : dma ? 4 : r == 4 ? 5 : 0;
      5: return r == 4 ? 5 : 0;
      default: return r == 4 ? 5 : irq ? 0 : s;
    endcase
  endfunction

  initial begin
    #800000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog expired got 0 exp 1");
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    clr_in();
    do_reset();
    // R1 reset state
    chk_out("R1 reset", 0, 0, 0);
    chk("R1 stall", int'(stall_o), 0);

    // sweep: every status x every single request, boundary strobes high
    for (int s = 0; s < 8; s++) begin
      for (int r = 0; r < 8; r++) begin
        int es, eg, eq;
        steer(s);
        clr_in();
        mc_end_i = 1; instr_end_i = 1;
        case (r)
          0: wait_i = 1;
          1: rfsh_req_i = 1;
          2: dreq_i = 2'b01;
          3: dreq_i = 2'b10;
          4: busreq_i = 1;
          default: irq_i = 3'(1 << (r - 5));
        endcase
        #1;
        chk("R2 stall", int'(stall_o),
            int'(r == 0 && (s == 0 || s == 1 || s == 3 || s == 4)));
        tick();
        es = exp_st(s, r);
        eg = (es == 4) ? ((s == 4 && r == 0) ? 1 : (r == 3 ? 2 : 1)) : 0;
        eq = (es == 3) ? ((s == 3 && r == 0) ? 1 : (1 << (r - 5))) : 0;
        chk_out($sformatf("R4 R5 R8 R9 R10 matrix s%0d r%0d", s, r), es, eg, eq);
      end
    end

    // R11 priority sweep from normal
    for (int m = 0; m < 32; m++) begin
      int es, eg, eq;
      do_reset();
      rfsh_req_i = m[0]; busreq_i = m[1]; dreq_i = {m[3], m[2]}; irq_i = {2'b00, m[4]};
      mc_end_i = 1; instr_end_i = 1;
      tick();
      es = m[0] ? 2 : m[1] ? 5 : (m[2] | m[3]) ? 4 : m[4] ? 3 : 0;
      eg = (es == 4) ? (m[2] ? 1 : 2) : 0;
      eq = (es == 3) ? 1 : 0;
      chk_out($sformatf("R11 prio m%0d", m), es, eg, eq);
    end

    // R6 DMA latched during refresh
    do_reset();
    rfsh_req_i = 1; mc_end_i = 1; tick();
    clr_in(); dreq_i = 2'b01; tick();
    chk_out("R6 R3 rfsh held", 2, 0, 0);
    clr_in(); mc_end_i = 1; tick();
    chk_out("R6 rfsh done", 0, 0, 0);
    tick();
    chk_out("R6 dma after rfsh", 4, 1, 0);
    tick();
    chk_out("R6 pend cleared", 0, 0, 0);

    // R7 DMA latched during bus release
    do_reset();
    busreq_i = 1; mc_end_i = 1; tick();
    mc_end_i = 0; dreq_i = 2'b10; tick();
    chk_out("R7 brel held", 5, 0, 0);
    clr_in(); mc_end_i = 1; tick();
    chk_out("R7 brel done", 0, 0, 0);
    tick();
    chk_out("R7 dma after brel", 4, 2, 0);

    // R8 release holds across boundaries while requested
    do_reset();
    busreq_i = 1; mc_end_i = 1; tick(); tick();
    chk_out("R8 brel hold", 5, 0, 0);

    // R9 release from sleep returns to sleep
    steer(6);
    clr_in(); busreq_i = 1; tick();
    chk_out("R9 sleep brel", 5, 0, 0);
    mc_end_i = 1; tick();
    chk_out("R9 sleep brel hold", 5, 0, 0);
    busreq_i = 0; tick();
    chk_out("R9 back to sleep", 6, 0, 0);
    mc_end_i = 0; irq_i = 3'b100; tick();
    chk_out("R10 wake", 0, 0, 0);

    // R9 stop beats sleep
    do_reset();
    sleep_cmd_i = 1; stop_cmd_i = 1; mc_end_i = 1; instr_end_i = 1; tick();
    chk_out("R9 stop over sleep", 7, 0, 0);

    // R10 needs instruction end; lowest line selected
    do_reset();
    irq_i = 3'b110; mc_end_i = 1; tick();
    chk_out("R10 no instr_end", 0, 0, 0);
    instr_end_i = 1; tick();
    chk_out("R10 iack sel", 3, 0, 2);

    // R3 no boundary: wait drop without mc_end returns to normal only
    do_reset();
    wait_i = 1; dreq_i = 2'b01; tick();
    chk_out("R2 wait", 1, 0, 0);
    wait_i = 0; tick();
    chk_out("R3 wait exit no boundary", 0, 0, 0);

    done = 1'b1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule